// File: doc/BRIEF.md
# Serial Audio Input Receiver

This block takes a stereo serial audio stream, made of a data line, a bit clock and a word clock, into the system clock domain. It turns the stream into a pair of parallel sample words, left and right, and raises a valid strobe for one cycle. All three serial lines are asynchronous to the system clock. They pass through a two-flop synchronizer, and their edges are found by oversampling. The system clock must therefore run several times faster than the bit clock.

Three static settings change the framing. The first chooses left-justified words of up to 24 bits or right-justified 16-bit words. The second chooses which bit-clock edge samples data. The third chooses which word-clock edge starts a frame.

The block counts the bit-clock edges in every half-frame. A count it does not accept raises a framing-error pulse and drops the pair being assembled. It also sets a hard-mute request that stays set until reset, so that downstream logic can silence the output.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted, and after it, the outputs `left_o`, `right_o`, `valid_o`, `frame_err_o` and `mute_req_o` are all zero until stimulus arrives.
- R2: With `cfg_rjust`=0, a half-frame of n bits, MSB first, gives a 24-bit word. For n<24 the n bits sit at the top of the word and the low bits are zero. For n>=24 the word is the first 24 bits received, and later bits are ignored.
- R3: With `cfg_rjust`=1, the word is the last 16 bits received before the closing word-clock edge, sign-extended from bit 15 to 24 bits.
- R4: With `cfg_bck_fall`=0, data is sampled on the rising bit-clock edge. With `cfg_bck_fall`=1, data is sampled on the falling edge. The data level at the other edge has no effect.
- R5: With `cfg_wck_inv`=0, a rising word-clock edge starts a frame: the left word is received while the word clock is high and closed by the falling edge, and the right word is closed by the next rising edge. With `cfg_wck_inv`=1, both edges are swapped.
- R6: The left and right words of one frame appear together, with `valid_o` high for exactly one cycle. Between strobes, `left_o` and `right_o` hold their values.
- R7: A half-frame passes when it has 16, 18, 20, or 24 or more active bit-clock edges. Any other count raises `frame_err_o` for one cycle, and that frame produces no strobe. The partial half-frame before the first word-clock edge after reset is not checked.
- R8: `mute_req_o` goes high together with the first framing error and stays high until reset.
- R9: `valid_o` rises on the third system-clock edge after the frame-closing word-clock transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdata_i | input | 1 | Serial data, asynchronous |
| sbclk_i | input | 1 | Bit clock, asynchronous |
| swclk_i | input | 1 | Word clock, asynchronous |
| cfg_rjust | input | 1 | 0 = left-justified up to 24 bits, 1 = right-justified 16 bits |
| cfg_bck_fall | input | 1 | 0 = sample data on rising bit-clock edge, 1 = on falling edge |
| cfg_wck_inv | input | 1 | 0 = rising word-clock edge starts a frame, 1 = falling edge |
| left_o | output | 24 | Left sample word |
| right_o | output | 24 | Right sample word |
| valid_o | output | 1 | One-cycle strobe for a new pair |
| frame_err_o | output | 1 | One-cycle pulse for a half-frame with a bad count |
| mute_req_o | output | 1 | Sticky hard-mute request |

## Verification
Every serial-line change reaches the outputs on the third rising system-clock edge after it. That is two synchronizer flops plus the register that acts on the edge. A word, strobe or error pulse therefore appears three cycles after the word-clock transition that closes its half-frame.

The bench changes inputs just after a falling clock edge and holds each bit-clock phase for four cycles. At the frame-closing edge it samples `valid_o` at the first, second and third falling edges that follow, and it expects the strobe only at the third. The words and the error count are read a few cycles later, once the strobe has passed.

// File: rtl/sar_pkg.sv
package sar_pkg;
   // events seen in the system clock domain for one clock cycle
   typedef struct packed {
      logic bit_stb;     // active bit-clock edge
      logic start_edge;  // word-clock edge that opens a frame
      logic mid_edge;    // word-clock edge that closes the left half
      logic din;         // data level aligned with the edges
   } sar_evt_t;

   // positions of the serial lines inside the synchronizer vector
   localparam int SAR_IDX_DAT = 0;
   localparam int SAR_IDX_BCK = 1;
   localparam int SAR_IDX_WCK = 2;
   localparam int SAR_LINES   = 3;
endpackage

// File: rtl/sar_sync_edge.sv
module sar_sync_edge #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] lvl_o,
   output logic [W-1:0] rise_o,
   output logic [W-1:0] fall_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sar_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         logic [W-1:0] q;
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) q <= '0;
               else        q <= async_i;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) q <= '0;
               else        q <= g_stage[s-1].q;
         end
      end
   endgenerate

   logic [W-1:0] prev_q;
   logic [STAGES:0] fill_q;   // edges are masked until the chain holds real samples

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         prev_q <= '0;
         fill_q <= '0;
      end else begin
         prev_q <= lvl_o;
         fill_q <= {fill_q[STAGES-1:0], 1'b1};
      end

   assign lvl_o  = g_stage[STAGES-1].q;
   assign rise_o = fill_q[STAGES] ? ( lvl_o & ~prev_q) : '0;
   assign fall_o = fill_q[STAGES] ? (~lvl_o &  prev_q) : '0;
endmodule

// File: rtl/sar_half_count.sv
module sar_half_count #(
   parameter int WORD_W = 24,
   parameter int RJ_W   = 16,
   parameter int CNT_W  = 6,
   parameter logic [WORD_W-1:0] ACCEPT_MASK = WORD_W'((1 << 16) | (1 << 18) | (1 << 20))
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_stb_i,
   input  logic              boundary_i,
   input  logic              din_i,
   input  logic              rjust_i,
   output logic [WORD_W-1:0] word_o,
   output logic              count_ok_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] FULL_C  = CNT_W'(WORD_W);

   generate
      if (WORD_W >= (1 << CNT_W) - 1) begin : g_bad_cnt
         $error("sar_half_count: CNT_W too small for WORD_W");
      end
      if (RJ_W >= WORD_W || RJ_W < 2) begin : g_bad_rj
         $error("sar_half_count: RJ_W must be in 2..WORD_W-1");
      end
   endgenerate

   logic [CNT_W-1:0]  cnt_q;
   logic [WORD_W-1:0] lj_q;
   logic [RJ_W-1:0]   rj_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         cnt_q <= '0;
         lj_q  <= '0;
         rj_q  <= '0;
      end else if (boundary_i) begin
         // a bit strobe coinciding with a word-clock edge opens the new half
         cnt_q <= bit_stb_i ? CNT_W'(1) : '0;
         lj_q  <= bit_stb_i ? WORD_W'(din_i) : '0;
         rj_q  <= bit_stb_i ? RJ_W'(din_i) : '0;
      end else if (bit_stb_i) begin
         if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
         if (cnt_q < FULL_C)   lj_q  <= {lj_q[WORD_W-2:0], din_i};
         rj_q <= {rj_q[RJ_W-2:0], din_i};
      end

   always_comb begin
      if (rjust_i)              word_o = {{(WORD_W-RJ_W){rj_q[RJ_W-1]}}, rj_q};
      else if (cnt_q >= FULL_C) word_o = lj_q;
      else                      word_o = lj_q << (FULL_C - cnt_q);
   end

   always_comb begin
      count_ok_o = (cnt_q >= FULL_C);
      for (int k = 0; k < WORD_W; k++)
         if (ACCEPT_MASK[k] && cnt_q == CNT_W'(k)) count_ok_o = 1'b1;
   end
endmodule

// File: rtl/sar_frame_ctl.sv
module sar_frame_ctl #(
   parameter int WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_edge_i,
   input  logic              mid_edge_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              count_ok_i,
   output logic [WORD_W-1:0] left_o,
   output logic [WORD_W-1:0] right_o,
   output logic              valid_o,
   output logic              frame_err_o,
   output logic              mute_req_o
);
   logic              armed_q;
   logic              have_left_q;
   logic [WORD_W-1:0] left_hold_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         armed_q     <= 1'b0;
         have_left_q <= 1'b0;
         left_hold_q <= '0;
         left_o      <= '0;
         right_o     <= '0;
         valid_o     <= 1'b0;
         frame_err_o <= 1'b0;
         mute_req_o  <= 1'b0;
      end else begin
         valid_o     <= 1'b0;
         frame_err_o <= 1'b0;
         if (start_edge_i || mid_edge_i) begin
            armed_q <= 1'b1;
            if (armed_q && !count_ok_i) begin
               frame_err_o <= 1'b1;
               mute_req_o  <= 1'b1;
               have_left_q <= 1'b0;
            end else if (armed_q && mid_edge_i) begin
               left_hold_q <= word_i;
               have_left_q <= 1'b1;
            end else if (armed_q && have_left_q) begin
               left_o      <= left_hold_q;
               right_o     <= word_i;
               valid_o     <= 1'b1;
               have_left_q <= 1'b0;
            end else begin
               have_left_q <= 1'b0;
            end
         end
      end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
   parameter int WORD_W      = 24,
   parameter int RJ_W        = 16,
   parameter int CNT_W       = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sdata_i,
   input  logic              sbclk_i,
   input  logic              swclk_i,
   input  logic              cfg_rjust,
   input  logic              cfg_bck_fall,
   input  logic              cfg_wck_inv,
   output logic [WORD_W-1:0] left_o,
   output logic [WORD_W-1:0] right_o,
   output logic              valid_o,
   output logic              frame_err_o,
   output logic              mute_req_o
);
   import sar_pkg::*;

   logic [SAR_LINES-1:0] raw, lvl, rise, fall;
   sar_evt_t             evt;
   logic [WORD_W-1:0]    word;
   logic                 count_ok;

   always_comb begin
      raw              = '0;
      raw[SAR_IDX_DAT] = sdata_i;
      raw[SAR_IDX_BCK] = sbclk_i;
      raw[SAR_IDX_WCK] = swclk_i;
   end

   sar_sync_edge #(.W(SAR_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(raw),
      .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
   );

   always_comb begin
      evt.bit_stb    = cfg_bck_fall ? fall[SAR_IDX_BCK] : rise[SAR_IDX_BCK];
      evt.start_edge = cfg_wck_inv  ? fall[SAR_IDX_WCK] : rise[SAR_IDX_WCK];
      evt.mid_edge   = cfg_wck_inv  ? rise[SAR_IDX_WCK] : fall[SAR_IDX_WCK];
      evt.din        = lvl[SAR_IDX_DAT];
   end

   sar_half_count #(.WORD_W(WORD_W), .RJ_W(RJ_W), .CNT_W(CNT_W)) u_half (
      .clk(clk), .rst_n(rst_n),
      .bit_stb_i(evt.bit_stb),
      .boundary_i(evt.start_edge | evt.mid_edge),
      .din_i(evt.din), .rjust_i(cfg_rjust),
      .word_o(word), .count_ok_o(count_ok)
   );

   sar_frame_ctl #(.WORD_W(WORD_W)) u_frame (
      .clk(clk), .rst_n(rst_n),
      .start_edge_i(evt.start_edge), .mid_edge_i(evt.mid_edge),
      .word_i(word), .count_ok_i(count_ok),
      .left_o(left_o), .right_o(right_o), .valid_o(valid_o),
      .frame_err_o(frame_err_o), .mute_req_o(mute_req_o)
   );
endmodule

// File: rtl/sar_rx_chk.sv
module sar_rx_chk #(
   parameter int WORD_W = 24,
   parameter int RJ_W   = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_rjust,
   input logic [WORD_W-1:0] left_o,
   input logic [WORD_W-1:0] right_o,
   input logic              valid_o,
   input logic              frame_err_o,
   input logic              mute_req_o
);
   logic [WORD_W-RJ_W:0] ext_bits;
   assign ext_bits = right_o[WORD_W-1:RJ_W-1];

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (!valid_o && !frame_err_o && !mute_req_o && left_o == '0 && right_o == '0));

   // R6
   valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R6
   pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> ($stable(left_o) && $stable(right_o)));

   // R3
   rj_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && cfg_rjust && $past(cfg_rjust)) |-> ((&ext_bits) || !(|ext_bits)));

   // R7
   err_no_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err_o |-> (!valid_o && mute_req_o));

   // R8
   mute_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mute_req_o |=> mute_req_o);
endmodule

bind serial_audio_rx sar_rx_chk #(.WORD_W(WORD_W), .RJ_W(RJ_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_rjust(cfg_rjust),
   .left_o(left_o), .right_o(right_o), .valid_o(valid_o),
   .frame_err_o(frame_err_o), .mute_req_o(mute_req_o)
);

// File: tb/sim_serial_audio_rx.sv
module sim_serial_audio_rx;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n = 1'b0;
   logic sdata = 1'b0, sbclk = 1'b0, swclk = 1'b0;
   logic cfg_rjust = 1'b0, cfg_bck_fall = 1'b0, cfg_wck_inv = 1'b0;
   logic [23:0] left_o, right_o;
   logic valid_o, frame_err_o, mute_req_o;

   serial_audio_rx u0 (
      .clk(clk), .rst_n(rst_n), .sdata_i(sdata), .sbclk_i(sbclk), .swclk_i(swclk),
      .cfg_rjust(cfg_rjust), .cfg_bck_fall(cfg_bck_fall), .cfg_wck_inv(cfg_wck_inv),
      .left_o(left_o), .right_o(right_o), .valid_o(valid_o),
      .frame_err_o(frame_err_o), .mute_req_o(mute_req_o)
   );

   int checks = 0, errors = 0, vcnt = 0, ecnt = 0;
   logic [23:0] cap_l = '0, cap_r = '0;
   bit done = 0;

   always @(negedge clk) begin
      if (valid_o) begin
         vcnt++;
         cap_l = left_o;
         cap_r = right_o;
      end
      if (frame_err_o) ecnt++;
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // data set at the inactive level, captured at the active edge, then
   // inverted at the return edge so a wrong-edge capture gets garbage (R4)
   task automatic send_bit(input logic b);
      sdata = b;
      wait_clk(4);
      sbclk = ~cfg_bck_fall;
      wait_clk(4);
      sbclk = cfg_bck_fall;
      sdata = ~b;
   endtask

   task automatic send_bits(input logic [31:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
      wait_clk(4);
   endtask

   task automatic wck_to(input logic lvl);
      swclk = lvl;
      wait_clk(4);
   endtask

   function automatic logic [23:0] exp_word(input logic [31:0] v, input int n, input bit rj);
      logic [31:0] m;
      m = (n >= 32) ? v : (v & ((32'd1 << n) - 1));
      if (rj)           return {{8{m[15]}}, m[15:0]};
      else if (n >= 24) return 24'(m >> (n - 24));
      else              return 24'(m << (24 - n));
   endfunction

   task automatic start_cfg(input bit rj, input bit fall, input bit inv);
      rst_n = 1'b0;
      cfg_rjust = rj; cfg_bck_fall = fall; cfg_wck_inv = inv;
      sbclk = fall; swclk = inv; sdata = 1'b0;
      wait_clk(6);
      rst_n = 1'b1;
      wait_clk(8);
      send_bits(32'h5, 3);          // partial half before the first edge
      wck_to(~inv);                  // first start edge arms the checker
   endtask

   task automatic frame(input logic [31:0] l, input int nl, input logic [31:0] r, input int nr,
                        input bit good, input string tag);
      int v0, e0;
      logic v1, v2, v3;
      v0 = vcnt; e0 = ecnt;
      send_bits(l, nl);
      wck_to(cfg_wck_inv);
      send_bits(r, nr);
      swclk = ~cfg_wck_inv;
      @(negedge clk) v1 = valid_o;
      @(negedge clk) v2 = valid_o;
      @(negedge clk) v3 = valid_o;
      wait_clk(4);
      if (good) begin
         chk(vcnt == v0 + 1, {tag, " R6 one strobe"}, vcnt - v0, 1);
         chk(cap_l == exp_word(l, nl, cfg_rjust), {tag, " left"}, cap_l, exp_word(l, nl, cfg_rjust));
         chk(cap_r == exp_word(r, nr, cfg_rjust), {tag, " right"}, cap_r, exp_word(r, nr, cfg_rjust));
         chk(!v1 && !v2 && v3, {tag, " R9 latency"}, {v1, v2, v3}, 3'b001);
      end else begin
         chk(vcnt == v0, {tag, " R7 no strobe"}, vcnt - v0, 0);
         chk(ecnt == e0 + 1, {tag, " R7 error pulse"}, ecnt - e0, 1);
      end
   endtask

   initial begin
      wait_clk(3);
      chk(left_o == 0 && right_o == 0, "R1 words reset", {left_o[15:0], right_o[15:0]}, 0);
      chk(!valid_o && !frame_err_o && !mute_req_o, "R1 flags reset",
          {valid_o, frame_err_o, mute_req_o}, 0);

      // R2 R5 left-justified, rising bit clock, rising start edge
      start_cfg(0, 0, 0);
      frame(32'hA5C3_E1, 24, 32'h1234_56, 24, 1, "R2 n24");
      frame(32'hBEEF, 16, 32'hF_0F0F, 20, 1, "R2 n16/20");
      frame(32'h2_ABCD, 18, 32'hDEAD_BEEF, 32, 1, "R2 n18/32");
      chk(ecnt == 0 && !mute_req_o, "R7 partial first half ignored", {ecnt[7:0], 7'b0, mute_req_o}, 0);

      // R3 right-justified
      start_cfg(1, 0, 0);
      frame(32'h8001, 16, 32'h7FFE, 16, 1, "R3 n16");
      frame(32'hFF_1234, 24, 32'h0012_C5A6, 32, 1, "R3 n24/32");

      // R4 falling bit clock
      start_cfg(0, 1, 0);
      frame(32'h3C_5A96, 24, 32'h96_3C5A, 24, 1, "R4 n24");
      frame(32'hC_3210, 20, 32'h9ABC, 16, 1, "R4 n20/16");

      // R5 inverted word clock
      start_cfg(0, 0, 1);
      frame(32'h11_2233, 24, 32'h2_FF00, 18, 1, "R5 inv");

      // R3 R4 R5 combined
      start_cfg(1, 1, 1);
      frame(32'hC001, 16, 32'h00_7F80, 24, 1, "R5 R4 R3 combined");

      // R7 R8 framing errors
      start_cfg(0, 0, 0);
      frame(32'h1_5555, 17, 32'hAB_CDEF, 24, 0, "R7 left n17");
      chk(mute_req_o, "R8 mute set", mute_req_o, 1);
      frame(32'h65_4321, 24, 32'h13_5791, 24, 1, "R8 good after error");
      chk(mute_req_o, "R8 mute sticky", mute_req_o, 1);
      frame(32'h24_6802, 24, 32'hABC, 12, 0, "R7 right n12");
      rst_n = 1'b0;
      wait_clk(3);
      chk(!mute_req_o, "R8 reset clears mute", mute_req_o, 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule